// File: doc/BRIEF.md
# Dual-Mode Direct-Mapped Cache Controller

This block sits between a CPU request port and a backing memory port and keeps a direct-mapped copy of 128-bit lines. Each line has a tag, a valid bit and a dirty bit. The `cache_mode` pin selects one of two policies. In combined instruction/data mode (0), every user-space read to the internal DRAM region can be cached, and write hits are held in the cache (copy-back). In instruction-only mode (1), only instruction fetches are cached. In that mode, writes always go to memory and never touch the cached copy, so the cache can hold stale data until software issues a purge.

Both ports use valid/ready. **CPU port.** A request is accepted on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. The CPU must hold the request fields stable until that cycle. Every accepted request, read or write, produces exactly one single-cycle `cpu_rsp_valid` pulse. The response channel has no back-pressure. `cpu_req_ready` stays low while a miss, an uncached access, a memory write or a purge is in progress.

**Memory port.** The block holds `mem_req_valid` and every request field stable until `mem_req_ready` is seen high. A write completes on that handshake. A read completes later, when `mem_rsp_valid` returns the full line.

The purge command walks every line, writes back each line that is both valid and dirty, and then drops all lines.

Top module: `dmc_cache_ctrl`

## Requirements
- R1: After reset, no line is valid or dirty, `cpu_req_ready` is 1, `purge_busy` is 0 and `cpu_rsp_valid` is 0, so the first cacheable read causes a memory line read.
- R2: CPU addresses are word aligned (bits 1:0 zero). A line is 128 bits. The index is address bits 11:4 (256 lines) and the tag is bits 31:12. Fills and write-backs use the line-aligned address, and write-backs use wmask 4'b1111.
- R3: In mode 0, a read is cacheable only if space=0, ext=0 and address bits 31:24 equal those of the DRAM base (0 by default). Any other read is bypassed: one memory line read per access, with nothing installed.
- R4: In mode 1, only reads with fetch=1, space=0 and ext=0 are cacheable, at any address. Data reads always go to memory.
- R5: A cacheable read hit returns the word with `cpu_rsp_valid` in the cycle after acceptance, and makes no memory transfer.
- R6: In mode 0, a write hit updates only the cached word, sets the line's dirty bit and responds in the cycle after acceptance, with no memory transfer.
- R7: In mode 1, a write hit becomes a single-word memory write with wmask bit addr[3:2] set. The cached line is left unchanged and valid, so a later fetch returns the old data without a memory read.
- R8: A write miss becomes a single-word memory write (wmask bit addr[3:2]) and allocates no line, so a later read of that line reads memory.
- R9: On a mode-0 cacheable read miss, a victim that is valid and dirty is written back before the fill read. A clean victim is refilled with no write.
- R10: On a mode-1 miss, the dirty bit is ignored and the line is refilled with no write-back.
- R11: A one-cycle `purge_req` in the idle state raises `purge_busy` and drops `cpu_req_ready` from the next cycle. The purge writes back every valid and dirty line, then leaves no line valid.
- R12: A memory request is held stable until `mem_req_ready`. `cpu_req_ready` is low in the cycle after a miss is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_mode | input | 1 | 0 = instruction/data copy-back, 1 = instruction-only |
| purge_req | input | 1 | Start a whole-cache purge (sampled in idle) |
| purge_busy | output | 1 | High while the purge walk runs |
| cpu_req_valid | input | 1 | CPU request valid |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_fetch | input | 1 | Read is an instruction fetch |
| cpu_req_space | input | 1 | Space identifier: 0 user, 1 I/O |
| cpu_req_ext | input | 1 | Request comes from an external bus master |
| cpu_req_addr | input | 32 | Byte address, word aligned |
| cpu_req_wdata | input | 32 | Write word |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_rdata | output | 32 | Read word (unspecified for writes) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = line read |
| mem_req_addr | output | 32 | Line-aligned address |
| mem_req_wdata | output | 128 | Write line data |
| mem_req_wmask | output | 4 | Per-word write enable |
| mem_rsp_valid | input | 1 | Read line returned |
| mem_rsp_rdata | input | 128 | Returned line |

## Verification
A corrupted tag or valid bit turns into a wrong word or a missing or extra memory read on the very next access to that index. The bench sees this through the latency of the response and through its count of memory reads.

A lost or spurious dirty bit shows up as a missing or extra line write. This is visible when the line is evicted in mode 0 or at the next purge, and the bench compares its own memory image against the written words at that point.

A stale-data error in instruction-only mode is only visible at the next fetch of the written line. The bench therefore fetches the line immediately after the write, and again after a purge.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_WORD,
    ST_PG_SCAN,
    ST_PG_WB
  } dmc_state_e;

  typedef enum logic {
    MODE_INSTR_DATA = 1'b0,
    MODE_INSTR_ONLY = 1'b1
  } dmc_mode_e;
endpackage

// File: rtl/dmc_space_decode.sv
module dmc_space_decode #(
  parameter int ADDR_W = 32,
  parameter int REGION_BITS = 24,
  parameter logic [ADDR_W-1:0] REGION_BASE = '0
) (
  input  logic              mode_ionly,
  input  logic              req_fetch,
  input  logic              req_space,
  input  logic              req_ext,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rd_cacheable,
  output logic              wr_lookup
);
  logic in_region;
  logic user_ok;

  assign in_region = (req_addr[ADDR_W-1:REGION_BITS] == REGION_BASE[ADDR_W-1:REGION_BITS]);
  assign user_ok   = !req_space && !req_ext;

  always_comb begin
    if (mode_ionly) rd_cacheable = user_ok && req_fetch;
    else            rd_cacheable = user_ok && in_region;
  end

  // A write can only hit a line that a cacheable read installed earlier.
  assign wr_lookup = user_ok;
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty,
  input  logic             install_en,
  input  logic [IDX_W-1:0] install_idx,
  input  logic [TAG_W-1:0] install_tag,
  input  logic             dirty_set_en,
  input  logic [IDX_W-1:0] dirty_idx,
  input  logic             clear_all,
  output logic             any_valid
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (clear_all) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (install_en) begin
        valid_q[install_idx] <= 1'b1;
        dirty_q[install_idx] <= 1'b0;
      end
      if (dirty_set_en) dirty_q[dirty_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install_en) tag_q[install_idx] <= install_tag;
  end

  assign rd_tag    = tag_q[rd_idx];
  assign rd_valid  = valid_q[rd_idx];
  assign rd_dirty  = dirty_q[rd_idx];
  assign any_valid = |valid_q;

  AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_set_en |-> valid_q[dirty_idx]); // R6
  AST_NO_FILL_DURING_WRITE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(install_en && dirty_set_en)); // R6
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int IDX_W  = 8,
  parameter int LINE_W = 128,
  parameter int WORD_W = 32
) (
  input  logic                              clk,
  input  logic [IDX_W-1:0]                  rd_idx,
  output logic [LINE_W-1:0]                 rd_line,
  input  logic                              fill_en,
  input  logic [IDX_W-1:0]                  fill_idx,
  input  logic [LINE_W-1:0]                 fill_line,
  input  logic                              word_we,
  input  logic [IDX_W-1:0]                  word_idx,
  input  logic [$clog2(LINE_W/WORD_W)-1:0]  word_sel,
  input  logic [WORD_W-1:0]                 word_data
);
  localparam int LINES  = 1 << IDX_W;
  localparam int WORDS  = LINE_W / WORD_W;
  localparam int WSEL_W = $clog2(WORDS);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] bank [LINES];
    always_ff @(posedge clk) begin
      if (fill_en)
        bank[fill_idx] <= fill_line[w*WORD_W +: WORD_W];
      else if (word_we && (word_sel == WSEL_W'(w)))
        bank[word_idx] <= word_data;
    end
    assign rd_line[w*WORD_W +: WORD_W] = bank[rd_idx];
  end
endmodule

// File: rtl/dmc_cache_ctrl.sv
module dmc_cache_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int LINE_W = 128,
  parameter int IDX_W  = 8,
  parameter int DRAM_REGION_BITS = 24,
  parameter logic [ADDR_W-1:0] DRAM_BASE = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cache_mode,
  input  logic                       purge_req,
  output logic                       purge_busy,
  input  logic                       cpu_req_valid,
  output logic                       cpu_req_ready,
  input  logic                       cpu_req_write,
  input  logic                       cpu_req_fetch,
  input  logic                       cpu_req_space,
  input  logic                       cpu_req_ext,
  input  logic [ADDR_W-1:0]          cpu_req_addr,
  input  logic [WORD_W-1:0]          cpu_req_wdata,
  output logic                       cpu_rsp_valid,
  output logic [WORD_W-1:0]          cpu_rsp_rdata,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic                       mem_req_write,
  output logic [ADDR_W-1:0]          mem_req_addr,
  output logic [LINE_W-1:0]          mem_req_wdata,
  output logic [LINE_W/WORD_W-1:0]   mem_req_wmask,
  input  logic                       mem_rsp_valid,
  input  logic [LINE_W-1:0]          mem_rsp_rdata
);
  localparam int WORDS    = LINE_W / WORD_W;
  localparam int WSEL_W   = $clog2(WORDS);
  localparam int BYTE_OFF = $clog2(WORD_W / 8);
  localparam int OFF_W    = $clog2(LINE_W / 8);
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;

  dmc_state_e state;

  logic [TAG_W-1:0]  r_tag, r_vtag;
  logic [IDX_W-1:0]  r_idx, pg_idx;
  logic [WSEL_W-1:0] r_wsel;
  logic [WORD_W-1:0] r_wdata;
  logic              r_fill, r_mode, r_space, r_ext;
  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_data_q;

  logic [TAG_W-1:0]  in_tag;
  logic [IDX_W-1:0]  in_idx;
  logic [WSEL_W-1:0] in_wsel;
  assign in_tag  = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign in_idx  = cpu_req_addr[OFF_W +: IDX_W];
  assign in_wsel = cpu_req_addr[BYTE_OFF +: WSEL_W];

  logic              mode_ionly;
  logic              rd_cacheable, wr_lookup;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  logic              look_valid, look_dirty, any_valid;
  logic [LINE_W-1:0] look_line;
  logic              accept, cur_hit, id_wr_hit, fill_done, pg_last, clear_all;

  assign mode_ionly = (cache_mode == MODE_INSTR_ONLY);

  dmc_space_decode #(
    .ADDR_W(ADDR_W), .REGION_BITS(DRAM_REGION_BITS), .REGION_BASE(DRAM_BASE)
  ) u_decode (
    .mode_ionly  (mode_ionly),
    .req_fetch   (cpu_req_fetch),
    .req_space   (cpu_req_space),
    .req_ext     (cpu_req_ext),
    .req_addr    (cpu_req_addr),
    .rd_cacheable(rd_cacheable),
    .wr_lookup   (wr_lookup)
  );

  // One lookup port: request index while idle, purge cursor while purging,
  // latched index during a miss or write-back.
  always_comb begin
    if (state == ST_IDLE)                             look_idx = in_idx;
    else if (state == ST_PG_SCAN || state == ST_PG_WB) look_idx = pg_idx;
    else                                               look_idx = r_idx;
  end

  assign cpu_req_ready = (state == ST_IDLE) && !purge_req;
  assign purge_busy    = (state == ST_PG_SCAN) || (state == ST_PG_WB);
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign cur_hit       = look_valid && (look_tag == in_tag);
  assign id_wr_hit     = accept && cpu_req_write && wr_lookup && cur_hit && !mode_ionly;
  assign fill_done     = (state == ST_RD_WAIT) && mem_rsp_valid && r_fill;
  assign pg_last       = (pg_idx == {IDX_W{1'b1}});
  assign clear_all     = ((state == ST_PG_SCAN) && !(look_valid && look_dirty) && pg_last) ||
                         ((state == ST_PG_WB) && mem_req_ready && pg_last);

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_idx      (look_idx),
    .rd_tag      (look_tag),
    .rd_valid    (look_valid),
    .rd_dirty    (look_dirty),
    .install_en  (fill_done),
    .install_idx (r_idx),
    .install_tag (r_tag),
    .dirty_set_en(id_wr_hit),
    .dirty_idx   (in_idx),
    .clear_all   (clear_all),
    .any_valid   (any_valid)
  );

  dmc_line_store #(.IDX_W(IDX_W), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_lines (
    .clk      (clk),
    .rd_idx   (look_idx),
    .rd_line  (look_line),
    .fill_en  (fill_done),
    .fill_idx (r_idx),
    .fill_line(mem_rsp_rdata),
    .word_we  (id_wr_hit),
    .word_idx (in_idx),
    .word_sel (in_wsel),
    .word_data(cpu_req_wdata)
  );

  function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] l,
                                                  input logic [WSEL_W-1:0] s);
    return l[s*WORD_W +: WORD_W];
  endfunction

  // Memory request outputs depend on state and latched fields only.
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = {r_tag, r_idx, {OFF_W{1'b0}}};
    mem_req_wdata = look_line;
    mem_req_wmask = '1;
    unique case (state)
      ST_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = {r_vtag, r_idx, {OFF_W{1'b0}}};
      end
      ST_RD_REQ: begin
        mem_req_valid = 1'b1;
      end
      ST_WR_WORD: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_wdata = {WORDS{r_wdata}};
        mem_req_wmask = WORDS'(1) << r_wsel;
      end
      ST_PG_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = {look_tag, pg_idx, {OFF_W{1'b0}}};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      pg_idx      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      r_tag       <= '0;
      r_vtag      <= '0;
      r_idx       <= '0;
      r_wsel      <= '0;
      r_wdata     <= '0;
      r_fill      <= 1'b0;
      r_mode      <= 1'b0;
      r_space     <= 1'b0;
      r_ext       <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (purge_req) begin
            pg_idx <= '0;
            state  <= ST_PG_SCAN;
          end else if (accept) begin
            r_tag   <= in_tag;
            r_idx   <= in_idx;
            r_wsel  <= in_wsel;
            r_wdata <= cpu_req_wdata;
            r_mode  <= mode_ionly;
            r_space <= cpu_req_space;
            r_ext   <= cpu_req_ext;
            r_vtag  <= look_tag;
            r_fill  <= !cpu_req_write && rd_cacheable;
            if (cpu_req_write) begin
              if (id_wr_hit) rsp_valid_q <= 1'b1;
              else           state       <= ST_WR_WORD;
            end else if (rd_cacheable && cur_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= pick_word(look_line, in_wsel);
            end else if (rd_cacheable && !mode_ionly && look_valid && look_dirty) begin
              state <= ST_WB;
            end else begin
              state <= ST_RD_REQ;
            end
          end
        end
        ST_WB:      if (mem_req_ready) state <= ST_RD_REQ;
        ST_RD_REQ:  if (mem_req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid) begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= pick_word(mem_rsp_rdata, r_wsel);
          state       <= ST_IDLE;
        end
        ST_WR_WORD: if (mem_req_ready) begin
          rsp_valid_q <= 1'b1;
          state       <= ST_IDLE;
        end
        ST_PG_SCAN: begin
          if (look_valid && look_dirty) state <= ST_PG_WB;
          else if (pg_last)             state <= ST_IDLE;
          else                          pg_idx <= pg_idx + 1'b1;
        end
        ST_PG_WB: if (mem_req_ready) begin
          if (pg_last) state <= ST_IDLE;
          else begin
            pg_idx <= pg_idx + 1'b1;
            state  <= ST_PG_SCAN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_rdata = rsp_data_q;

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid |-> (cpu_req_addr[BYTE_OFF-1:0] == '0)); // R2
  AST_WMASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (&mem_req_wmask || $countones(mem_req_wmask) == 1)); // R2
  AST_FILL_USER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> (!r_space && !r_ext)); // R3
  AST_NO_WB_IONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WB) |-> !r_mode); // R10
  AST_READY_LOW_PURGE: assert property (@(posedge clk) disable iff (!rst_n)
    purge_busy |-> !cpu_req_ready); // R11
  AST_PURGE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(purge_busy) |-> !any_valid); // R11
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
       $stable(mem_req_wmask) && $stable(mem_req_wdata))); // R12
endmodule

// File: tb/dmc_cache_ctrl_bench.sv
`timescale 1ns/1ps
module dmc_cache_ctrl_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cache_mode = 1'b0;
  logic         purge_req = 1'b0;
  logic         purge_busy;
  logic         cpu_req_valid = 1'b0;
  logic         cpu_req_ready;
  logic         cpu_req_write = 1'b0;
  logic         cpu_req_fetch = 1'b0;
  logic         cpu_req_space = 1'b0;
  logic         cpu_req_ext = 1'b0;
  logic [31:0]  cpu_req_addr = '0;
  logic [31:0]  cpu_req_wdata = '0;
  logic         cpu_rsp_valid;
  logic [31:0]  cpu_rsp_rdata;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic         mem_req_write;
  logic [31:0]  mem_req_addr;
  logic [127:0] mem_req_wdata;
  logic [3:0]   mem_req_wmask;
  logic         mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_rdata = '0;

  always #4 clk = ~clk;

  dmc_cache_ctrl u_dmc_cache_ctrl (.*);

  int nchk = 0;
  int nfail = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [31:0] last_wr_addr = '0;
  logic [3:0]  last_wr_mask = '0;
  logic [127:0] mem_st [logic [31:0]];

  function automatic logic [127:0] mem_line(input logic [31:0] la);
    logic [127:0] l;
    if (mem_st.exists(la)) return mem_st[la];
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = (la + 32'(w*4)) ^ 32'h5A5A_0000;
    return l;
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [127:0] l;
    l = mem_line({a[31:4], 4'b0});
    return l[a[3:2]*32 +: 32];
  endfunction

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  // Backing memory: one wait state before ready, read data one cycle after handshake.
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_req_ready <= 1'b0;
      if (mem_req_write) begin
        logic [127:0] l;
        l = mem_line(mem_req_addr);
        for (int w = 0; w < 4; w++)
          if (mem_req_wmask[w]) l[w*32 +: 32] = mem_req_wdata[w*32 +: 32];
        mem_st[mem_req_addr] = l;
        wr_cnt <= wr_cnt + 1;
        last_wr_addr <= mem_req_addr;
        last_wr_mask <= mem_req_wmask;
      end else begin
        rd_cnt <= rd_cnt + 1;
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem_line(mem_req_addr);
      end
    end else if (mem_req_valid) begin
      mem_req_ready <= 1'b1;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic cpu_access(input logic wr, input logic fe, input logic sp, input logic ex,
                            input logic [31:0] a, input logic [31:0] wd,
                            output logic [31:0] rd, output int lat, output logic rdy_after);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_fetch = fe;
    cpu_req_space = sp; cpu_req_ext = ex; cpu_req_addr = a; cpu_req_wdata = wd;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    rdy_after = cpu_req_ready;
    lat = 1;
    while (!cpu_rsp_valid) begin @(negedge clk); lat++; end
    rd = cpu_rsp_rdata;
  endtask

  logic [31:0] d;
  int lat;
  logic ra;
  int r0, w0;

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready after reset", 32'(cpu_req_ready), 1);
    chk("R1 busy after reset", 32'(purge_busy), 0);
    chk("R1 no response after reset", 32'(cpu_rsp_valid), 0);
  endtask

  task automatic t_fill_hit();
    r0 = rd_cnt;
    cpu_access(0, 0, 0, 0, 32'h0000_1040, 0, d, lat, ra);
    chk("R1 first read fills", 32'(rd_cnt - r0), 1);
    chk("R3 fill data", d, pat(32'h0000_1040));
    chk("R12 ready low after miss", 32'(ra), 0);
    cpu_access(0, 0, 0, 0, 32'h0000_1044, 0, d, lat, ra);
    chk("R5 hit data same line", d, pat(32'h0000_1044));
    chk("R5 hit latency", 32'(lat), 1);
    chk("R5 hit no memory read", 32'(rd_cnt - r0), 1);
  endtask

  task automatic t_write_hit_id();
    w0 = wr_cnt;
    cpu_access(1, 0, 0, 0, 32'h0000_1048, 32'hCAFE_0001, d, lat, ra);
    chk("R6 write hit latency", 32'(lat), 1);
    chk("R6 write hit no memory write", 32'(wr_cnt - w0), 0);
    chk("R6 memory stays old", mem_word(32'h0000_1048), pat(32'h0000_1048));
    cpu_access(0, 0, 0, 0, 32'h0000_1048, 0, d, lat, ra);
    chk("R6 read back cached word", d, 32'hCAFE_0001);
  endtask

  task automatic t_replace_dirty();
    w0 = wr_cnt; r0 = rd_cnt;
    cpu_access(0, 0, 0, 0, 32'h0000_2040, 0, d, lat, ra);
    chk("R9 victim written back", 32'(wr_cnt - w0), 1);
    chk("R9 written word", mem_word(32'h0000_1048), 32'hCAFE_0001);
    chk("R2 whole line written", mem_word(32'h0000_1040), pat(32'h0000_1040));
    chk("R2 write-back address", last_wr_addr, 32'h0000_1040);
    chk("R2 write-back mask", 32'(last_wr_mask), 32'hF);
    chk("R9 new line data", d, pat(32'h0000_2040));
    chk("R9 one fill read", 32'(rd_cnt - r0), 1);
  endtask

  task automatic t_replace_clean();
    w0 = wr_cnt;
    cpu_access(0, 0, 0, 0, 32'h0000_1048, 0, d, lat, ra);
    chk("R9 clean victim not written", 32'(wr_cnt - w0), 0);
    chk("R9 refilled from memory", d, 32'hCAFE_0001);
  endtask

  task automatic t_write_miss();
    w0 = wr_cnt; r0 = rd_cnt;
    cpu_access(1, 0, 0, 0, 32'h0000_3084, 32'h1234_5678, d, lat, ra);
    chk("R8 miss write goes out", 32'(wr_cnt - w0), 1);
    chk("R8 word mask", 32'(last_wr_mask), 32'h2);
    chk("R8 memory updated", mem_word(32'h0000_3084), 32'h1234_5678);
    cpu_access(0, 0, 0, 0, 32'h0000_3084, 0, d, lat, ra);
    chk("R8 no allocate: read misses", 32'(rd_cnt - r0), 1);
    chk("R8 read value", d, 32'h1234_5678);
  endtask

  task automatic t_bypass();
    r0 = rd_cnt;
    cpu_access(0, 0, 1, 0, 32'h0000_1100, 0, d, lat, ra);
    cpu_access(0, 0, 1, 0, 32'h0000_1100, 0, d, lat, ra);
    chk("R3 io space not cached", 32'(rd_cnt - r0), 2);
    chk("R3 io data", d, pat(32'h0000_1100));
    r0 = rd_cnt;
    cpu_access(0, 0, 0, 1, 32'h0000_1200, 0, d, lat, ra);
    cpu_access(0, 0, 0, 1, 32'h0000_1200, 0, d, lat, ra);
    chk("R3 external master not cached", 32'(rd_cnt - r0), 2);
    r0 = rd_cnt;
    cpu_access(0, 0, 0, 0, 32'h2000_0040, 0, d, lat, ra);
    cpu_access(0, 0, 0, 0, 32'h2000_0040, 0, d, lat, ra);
    chk("R3 outside dram not cached", 32'(rd_cnt - r0), 2);
    chk("R3 outside dram data", d, pat(32'h2000_0040));
  endtask

  task automatic t_ionly();
    cache_mode = 1'b1;
    r0 = rd_cnt;
    cpu_access(0, 0, 0, 0, 32'h0000_5000, 0, d, lat, ra);
    cpu_access(0, 0, 0, 0, 32'h0000_5000, 0, d, lat, ra);
    chk("R4 data read not cached", 32'(rd_cnt - r0), 2);
    r0 = rd_cnt;
    cpu_access(0, 1, 0, 0, 32'h2000_0100, 0, d, lat, ra);
    cpu_access(0, 1, 0, 0, 32'h2000_0104, 0, d, lat, ra);
    chk("R4 fetch cached anywhere", 32'(rd_cnt - r0), 1);
    chk("R4 fetch hit latency", 32'(lat), 1);
    w0 = wr_cnt;
    cpu_access(1, 0, 0, 0, 32'h2000_0104, 32'hBEEF_0002, d, lat, ra);
    chk("R7 write-around", 32'(wr_cnt - w0), 1);
    chk("R7 word mask", 32'(last_wr_mask), 32'h2);
    chk("R7 memory updated", mem_word(32'h2000_0104), 32'hBEEF_0002);
    cpu_access(0, 1, 0, 0, 32'h2000_0104, 0, d, lat, ra);
    chk("R7 stale cached word", d, pat(32'h2000_0104));
    chk("R7 line still valid", 32'(rd_cnt - r0), 1);
  endtask

  task automatic t_ionly_replace();
    cache_mode = 1'b0;
    cpu_access(0, 0, 0, 0, 32'h0000_6010, 0, d, lat, ra);
    cpu_access(1, 0, 0, 0, 32'h0000_6010, 32'h0BAD_F00D, d, lat, ra);
    cache_mode = 1'b1;
    w0 = wr_cnt;
    cpu_access(0, 1, 0, 0, 32'h0000_7010, 0, d, lat, ra);
    chk("R10 dirty ignored", 32'(wr_cnt - w0), 0);
    chk("R10 dirty data dropped", mem_word(32'h0000_6010), pat(32'h0000_6010));
    chk("R10 new line data", d, pat(32'h0000_7010));
  endtask

  task automatic t_purge();
    int cyc;
    cache_mode = 1'b0;
    cpu_access(0, 0, 0, 0, 32'h0000_8020, 0, d, lat, ra);
    cpu_access(1, 0, 0, 0, 32'h0000_8020, 32'h1111_0000, d, lat, ra);
    cpu_access(0, 0, 0, 0, 32'h0000_90F0, 0, d, lat, ra);
    cpu_access(1, 0, 0, 0, 32'h0000_90F4, 32'h2222_0000, d, lat, ra);
    w0 = wr_cnt;
    @(negedge clk); purge_req = 1'b1;
    @(negedge clk); purge_req = 1'b0;
    chk("R11 busy raised", 32'(purge_busy), 1);
    chk("R11 ready low in purge", 32'(cpu_req_ready), 0);
    cyc = 0;
    while (purge_busy && cyc < 5000) begin @(negedge clk); cyc++; end
    chk("R11 purge finished", 32'(purge_busy), 0);
    chk("R11 dirty lines written", 32'(wr_cnt - w0), 2);
    chk("R11 first dirty word", mem_word(32'h0000_8020), 32'h1111_0000);
    chk("R11 second dirty word", mem_word(32'h0000_90F4), 32'h2222_0000);
    r0 = rd_cnt;
    cpu_access(0, 0, 0, 0, 32'h0000_8020, 0, d, lat, ra);
    chk("R11 lines invalid after purge", 32'(rd_cnt - r0), 1);
    chk("R11 read after purge", d, 32'h1111_0000);
    cache_mode = 1'b1;
    cpu_access(0, 1, 0, 0, 32'h2000_0104, 0, d, lat, ra);
    chk("R11 purge removes stale fetch", d, 32'hBEEF_0002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill_hit();
    t_write_hit_id();
    t_replace_dirty();
    t_replace_clean();
    t_write_miss();
    t_bypass();
    t_ionly();
    t_ionly_replace();
    t_purge();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule